// File: doc/BRIEF.md
# Startup Output Muter for an Audio ADC Serial Link

This block sits between the word formatter of an audio ADC and its serial data output pin. After the converter leaves power-down, or after the system clock comes back from a stop, the decimation filter takes some time before its samples are correct. During that time the block holds the serial output LOW. It then releases the line once the filter has had time to settle.

The settling time is measured in sample periods, not clock cycles. A one-cycle strobe marks each sample period, and the hold-off counter advances only on that strobe. A DC-cancel select input chooses between a short and a long settling length, because the high-pass DC removal stage takes much longer to settle. If the select changes while the hold-off is running, the count starts again with the new length. The data-valid flag rises on the strobe that completes the count. The serial line starts passing data on the next strobe, which is the next frame boundary, so no partial word leaves the pin.

Top module: `startup_muter`

## Requirements
- R1: Whenever `data_valid` is 0, `ser_out` is 0, whatever the value of `ser_in`.
- R2: After reset, `data_valid` is 0 and `ser_out` is 0.
- R3: A clock edge that samples `pwr_down` high clears `data_valid` and mutes `ser_out`. After `pwr_down` is released, the full hold-off has to elapse again.
- R4: A clock edge that samples `clk_ok` low has the same effect as power-down, and the hold-off starts again once `clk_ok` returns high.
- R5: With `dc_cancel` = 0, `data_valid` rises on exactly the 1024th strobe after the restart, and not on the 1023rd.
- R6: With `dc_cancel` = 1, `data_valid` rises on exactly the 12288th strobe after the restart, and not on the 12287th.
- R7: Only clock cycles with `smp_stb` high advance the hold-off. Idle cycles without a strobe never raise `data_valid`.
- R8: If `dc_cancel` changes before `data_valid` rises, the count returns to zero and the length chosen by the new value applies in full.
- R9: Once `data_valid` is high, a change of `dc_cancel` has no effect. `data_valid` stays high and `ser_out` keeps passing data.
- R10: In the cycle in which `data_valid` rises, `ser_out` is still 0. From the next strobe onwards, `ser_out` equals `ser_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock, free-running |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_down | input | 1 | High while the converter is powered down |
| clk_ok | input | 1 | High while the system clock is running |
| smp_stb | input | 1 | One-cycle pulse per sample period (frame boundary) |
| dc_cancel | input | 1 | 1 selects the long settling length (DC cancellation on) |
| ser_in | input | 1 | Serial data from the formatter |
| ser_out | output | 1 | Gated serial data towards the output pin |
| data_valid | output | 1 | High once the filter output can be trusted |

## Verification
On every cycle, the checker checks the following:
- The output is LOW whenever the valid flag is low.
- Power-down or a stopped clock clears the flag on the next edge.
- The flag rises only on a strobe.
- The flag never drops except through power-down or clock loss.
- The gate stays closed in the cycle the flag rises.

The exact hold-off lengths cannot be seen on a single cycle, so the bench's directed scenarios cover them:
- the strobe counts at which the flag rises for both settling selections;
- the restart after a mid-count change of the select;
- the full re-count after power-down and after clock loss;
- the alignment of the pass-through to the following strobe.

// File: rtl/muter_pkg.sv
package muter_pkg;

   // settling selection driven by the DC-cancel input
   typedef enum logic {
      SETTLE_SHORT = 1'b0,
      SETTLE_LONG  = 1'b1
   } settle_e;

   localparam int unsigned DEF_SHORT_LEN = 1024;
   localparam int unsigned DEF_LONG_LEN  = 12288;

endpackage

// File: rtl/muter_ctrl.sv
module muter_ctrl
   import muter_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    pwr_down,
   input  logic    clk_ok,
   input  logic    dc_cancel,
   input  logic    done,
   output logic    restart,
   output settle_e sel
);

   logic dc_q;
   logic sel_change;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dc_q <= 1'b0;
      else        dc_q <= dc_cancel;
   end

   // a select change matters only while the hold-off still runs
   assign sel_change = (dc_cancel != dc_q) && !done;
   assign restart    = pwr_down || !clk_ok || sel_change;
   assign sel        = dc_cancel ? SETTLE_LONG : SETTLE_SHORT;

endmodule

// File: rtl/holdoff_counter.sv
module holdoff_counter
   import muter_pkg::*;
#(
   parameter int unsigned SHORT_LEN = DEF_SHORT_LEN,
   parameter int unsigned LONG_LEN  = DEF_LONG_LEN,
   parameter int unsigned CNT_W     = $clog2(LONG_LEN + 1)
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    restart,
   input  logic    strobe,
   input  settle_e sel,
   output logic    done
);

   localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_LEN - 1);
   localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(LONG_LEN - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last;
   logic             done_q;
   logic             step;

   assign last = (sel == SETTLE_LONG) ? LAST_LONG : LAST_SHORT;
   assign step = strobe && !done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (restart) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (step) begin
         cnt_q <= cnt_q + 1'b1;   // stops once done_q is set
         if (cnt_q == last) done_q <= 1'b1;
      end
   end

   assign done = done_q;

endmodule

// File: rtl/mute_gate.sv
module mute_gate #(
   parameter bit REG_OUT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic strobe,
   input  logic done,
   input  logic ser_in,
   output logic ser_out
);

   logic pass_q;

   // open only at a frame boundary after the hold-off has ended
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pass_q <= 1'b0;
      else if (restart)          pass_q <= 1'b0;
      else if (strobe && done)   pass_q <= 1'b1;
   end

   generate
      if (REG_OUT) begin : g_reg
         logic out_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       out_q <= 1'b0;
            else if (restart) out_q <= 1'b0;
            else              out_q <= pass_q && ser_in;
         end
         assign ser_out = out_q;
      end else begin : g_comb
         assign ser_out = pass_q && ser_in;
      end
   endgenerate

endmodule

// File: rtl/startup_muter.sv
module startup_muter
   import muter_pkg::*;
#(
   parameter int unsigned SHORT_LEN = DEF_SHORT_LEN,
   parameter int unsigned LONG_LEN  = DEF_LONG_LEN,
   parameter bit          REG_OUT   = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_down,
   input  logic clk_ok,
   input  logic smp_stb,
   input  logic dc_cancel,
   input  logic ser_in,
   output logic ser_out,
   output logic data_valid
);

   localparam int unsigned CNT_W = $clog2(LONG_LEN + 1);

   generate
      if (SHORT_LEN < 1) begin : g_bad_short
         $error("startup_muter: SHORT_LEN must be at least 1");
      end
      if (LONG_LEN <= SHORT_LEN) begin : g_bad_long
         $error("startup_muter: LONG_LEN must exceed SHORT_LEN");
      end
   endgenerate

   logic    restart;
   logic    done;
   settle_e sel;

   muter_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwr_down  (pwr_down),
      .clk_ok    (clk_ok),
      .dc_cancel (dc_cancel),
      .done      (done),
      .restart   (restart),
      .sel       (sel)
   );

   holdoff_counter #(
      .SHORT_LEN (SHORT_LEN),
      .LONG_LEN  (LONG_LEN),
      .CNT_W     (CNT_W)
   ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .strobe  (smp_stb),
      .sel     (sel),
      .done    (done)
   );

   mute_gate #(
      .REG_OUT (REG_OUT)
   ) u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .strobe  (smp_stb),
      .done    (done),
      .ser_in  (ser_in),
      .ser_out (ser_out)
   );

   assign data_valid = done;

endmodule

// File: rtl/startup_muter_chk.sv
module startup_muter_chk (
   input logic clk,
   input logic rst_n,
   input logic pwr_down,
   input logic clk_ok,
   input logic smp_stb,
   input logic ser_out,
   input logic data_valid
);

   // R1
   mute_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !data_valid |-> !ser_out);

   // R3
   pd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down |=> !data_valid);

   // R4
   clk_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_ok |=> !data_valid);

   // R7
   rise_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_valid) |-> $past(smp_stb));

   // R9
   valid_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_valid && !pwr_down && clk_ok) |=> data_valid);

   // R10
   gate_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_valid) |-> !ser_out);

endmodule

bind startup_muter startup_muter_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pwr_down   (pwr_down),
   .clk_ok     (clk_ok),
   .smp_stb    (smp_stb),
   .ser_out    (ser_out),
   .data_valid (data_valid)
);

// File: tb/tb_startup_muter.sv
module tb_startup_muter;

   localparam time CLK_PERIOD = 10ns;
   localparam int  SHORT_N    = 1024;
   localparam int  LONG_N     = 12288;
   localparam int  WATCHDOG   = 190000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_down = 1'b0;
   logic clk_ok = 1'b1;
   logic smp_stb = 1'b0;
   logic dc_cancel = 1'b0;
   logic ser_in = 1'b1;
   logic ser_out;
   logic data_valid;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   startup_muter dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .pwr_down   (pwr_down),
      .clk_ok     (clk_ok),
      .smp_stb    (smp_stb),
      .dc_cancel  (dc_cancel),
      .ser_in     (ser_in),
      .ser_out    (ser_out),
      .data_valid (data_valid)
   );

   task automatic check(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic strobes(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) smp_stb = 1'b1;
         @(negedge clk) smp_stb = 1'b0;
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // power-down pulse that restarts the hold-off with the given select
   task automatic fresh_start(input logic sel);
      @(negedge clk);
      dc_cancel = sel;
      pwr_down  = 1'b1;
      @(negedge clk);
      pwr_down  = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset;
      check("R2", "valid after reset", data_valid, 1'b0);
      check("R2", "ser_out after reset", ser_out, 1'b0);
   endtask

   task automatic t_short;
      fresh_start(1'b0);
      ser_in = 1'b1;
      strobes(SHORT_N - 1);
      check("R5", "valid at 1023 strobes", data_valid, 1'b0);
      check("R1", "muted during hold-off", ser_out, 1'b0);
      strobes(1);
      check("R5", "valid at 1024 strobes", data_valid, 1'b1);
      check("R10", "still muted before next strobe", ser_out, 1'b0);
      strobes(1);
      check("R10", "passes 1 after next strobe", ser_out, 1'b1);
      ser_in = 1'b0;
      idle(1);
      check("R10", "passes 0 after next strobe", ser_out, 1'b0);
      ser_in = 1'b1;
   endtask

   task automatic t_long;
      fresh_start(1'b1);
      strobes(LONG_N - 1);
      check("R6", "valid at 12287 strobes", data_valid, 1'b0);
      check("R1", "muted during long hold-off", ser_out, 1'b0);
      strobes(1);
      check("R6", "valid at 12288 strobes", data_valid, 1'b1);
      strobes(1);
      check("R6", "passing after long hold-off", ser_out, 1'b1);
   endtask

   task automatic t_powerdown;
      fresh_start(1'b0);
      strobes(SHORT_N + 1);
      check("R3", "valid before power-down", data_valid, 1'b1);
      @(negedge clk) pwr_down = 1'b1;
      @(negedge clk);
      check("R3", "valid cleared by power-down", data_valid, 1'b0);
      check("R3", "muted by power-down", ser_out, 1'b0);
      pwr_down = 1'b0;
      strobes(SHORT_N - 1);
      check("R3", "full re-count after release", data_valid, 1'b0);
      strobes(1);
      check("R3", "valid after re-count", data_valid, 1'b1);
   endtask

   task automatic t_clock_loss;
      fresh_start(1'b0);
      strobes(SHORT_N + 1);
      @(negedge clk) clk_ok = 1'b0;
      @(negedge clk);
      check("R4", "valid cleared by clock stop", data_valid, 1'b0);
      check("R4", "muted by clock stop", ser_out, 1'b0);
      clk_ok = 1'b1;
      strobes(SHORT_N - 1);
      check("R4", "full re-count after clock return", data_valid, 1'b0);
      strobes(1);
      check("R4", "valid after clock return", data_valid, 1'b1);
   endtask

   task automatic t_sel_change_midway;
      fresh_start(1'b0);
      strobes(500);
      @(negedge clk) dc_cancel = 1'b1;
      strobes(LONG_N - 1);
      check("R8", "not valid before new full length", data_valid, 1'b0);
      strobes(1);
      check("R8", "valid after new full length", data_valid, 1'b1);
   endtask

   task automatic t_strobe_only;
      fresh_start(1'b0);
      strobes(SHORT_N - 1);
      idle(300);
      check("R7", "idle cycles do not count", data_valid, 1'b0);
      strobes(1);
      check("R7", "last strobe completes count", data_valid, 1'b1);
   endtask

   task automatic t_sel_change_after;
      fresh_start(1'b0);
      strobes(SHORT_N + 1);
      @(negedge clk) dc_cancel = 1'b1;
      idle(5);
      check("R9", "valid kept after select change", data_valid, 1'b1);
      check("R9", "still passing after select change", ser_out, 1'b1);
      strobes(3);
      check("R9", "valid kept after more strobes", data_valid, 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_short();
      t_long();
      t_powerdown();
      t_clock_loss();
      t_sel_change_midway();
      t_strobe_only();
      t_sel_change_after();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule